// File: doc/BRIEF.md
# Byte-Lane Synchronous RAM Port Controller

This block is the control side of one port of a synchronous static RAM. The RAM word is 36 bits wide and is cut into four 9-bit lanes. On each rising clock edge the controller decodes a mixed-polarity pair of port selects, a read/write line and one active-low enable per lane. From these it derives per-lane write strobes and per-lane read-drive enables. A small behavioural storage array is included so that the port can be exercised end to end.

Read results leave the block as a 36-bit data vector plus a 4-bit per-lane drive vector. This pair stands in for a tri-state bus and stays synthesizable. Two inputs act without the clock and force every lane quiet at once: an output-disable input and a doze input. Doze also blocks any access at the edges where it is high. A static parameter sets the read timing. In flow-through timing a read result is visible in the cycle after its capturing edge. In pipelined timing it appears one cycle later, and the lane mask and access type are registered together with the data.

The access decoded at each edge is held in a four-state register: `ACC_IDLE` (port not selected), `ACC_READ`, `ACC_WRITE` and `ACC_SLEEP` (doze high at the edge). There is a transition from every state to every state, taken on each edge. The target is `ACC_SLEEP` when doze is high. Otherwise it is `ACC_IDLE` when the port is not selected, `ACC_READ` when `rd_nwr` is high and `ACC_WRITE` when it is low. In pipelined timing a second register copies the first one cycle later. Only `ACC_READ` in the output-stage register lets lanes drive.

Top module: `lane_sram_port`

## Requirements
- R1: Lane k covers word bits [9k+8:9k] (lane 0 = bits 0..8, lane 3 = bits 27..35), and `lane_en_n[k]` alone gates lane k for both reads and writes.
- R2: The port is selected only when `sel_n`=0 and `sel`=1. At an edge with any other combination, nothing is written and no lane drives in that access's result cycle.
- R3: At a selected edge with `rd_nwr`=0, exactly the lanes with `lane_en_n[k]`=0 take `wdata` at `addr`. Every other lane keeps its stored value, and any mix of lanes may be written in one access.
- R4: At a selected edge with `rd_nwr`=1, `lane_drive[k]`=1 in the result cycle exactly for the lanes with `lane_en_n[k]`=0. The driven lanes of `rdata` carry the stored value at `addr`.
- R5: A selected access with `lane_en_n`=4'b1111 writes no lane and drives no lane.
- R6: While `out_disable`=1, `lane_drive` is 4'b0000 with no clock edge needed. When it returns to 0, the pending read result drives again.
- R7: While `doze`=1, `lane_drive` is 4'b0000 with no clock edge needed. An edge with `doze`=1 performs no write and produces no read result.
- R8: With `PIPELINED`=0, a read captured at edge N is visible from edge N until edge N+1. With `PIPELINED`=1, it is visible from edge N+1 until edge N+2.
- R9: Lanes of `rdata` whose `lane_drive` bit is 0 read as zero.
- R10: While `rst_n`=0, `lane_drive` is 4'b0000 and the access registers hold `ACC_IDLE`.
- R11: The result cycle of a write access drives no lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Port select, active low |
| sel | input | 1 | Port select, active high |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| lane_en_n | input | 4 | Per-lane enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 36 | Write data |
| out_disable | input | 1 | Asynchronous force of all lanes to not driven |
| doze | input | 1 | Asynchronous quiet input; also blocks access |
| rdata | output | 36 | Read data, zero on lanes not driven |
| lane_drive | output | 4 | Per-lane read-drive enable |

## Verification
The bench builds two instances side by side on the same stimulus: one with `PIPELINED`=0 and one with `PIPELINED`=1, both with a 16-word array (`ADDR_W`=4). Running both against one queue-based model shows the one-cycle shift between the two timings. It also covers the pipelined case where output-disable is high for the flow-through result but has fallen by the time the pipelined copy is sampled. The small depth lets the bench fill every word before reading, so every read is compared against known contents.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_SLEEP = 2'd3
    } acc_e;
endpackage

// File: rtl/lsp_decode.sv
module lsp_decode
    import lsp_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sel_n,
    input  logic             sel,
    input  logic             rd_nwr,
    input  logic             doze,
    input  logic [LANES-1:0] lane_en_n,
    output acc_e             next_acc,
    output logic [LANES-1:0] lane_sel,
    output logic [LANES-1:0] wr_stb
);
    logic selected;
    assign selected = !sel_n && sel;

    // next access type (R2, R7)
    always_comb begin
        if (doze)
            next_acc = ACC_SLEEP;
        else if (!selected)
            next_acc = ACC_IDLE;
        else if (rd_nwr)
            next_acc = ACC_READ;
        else
            next_acc = ACC_WRITE;
    end

    // per-lane qualifiers (R1, R3, R5)
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_sel[g] = ~lane_en_n[g];
        assign wr_stb[g]   = (next_acc == ACC_WRITE) && lane_sel[g];
    end
endmodule

// File: rtl/lsp_fsm.sv
module lsp_fsm
    import lsp_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int ADDR_W    = 4,
    parameter bit PIPELINED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              next_acc,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  read_lanes
);
    acc_e             acc_q;
    logic [LANES-1:0] mask_q;
    acc_e             out_acc;
    logic [LANES-1:0] out_mask;

    // state register: access captured at this edge (R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= ACC_IDLE;
            mask_q <= '0;
            addr_q <= '0;
        end else begin
            acc_q  <= next_acc;
            mask_q <= lane_sel;
            addr_q <= addr;
        end
    end

    // output-stage selection by read timing (R8)
    if (PIPELINED) begin : g_pipe
        acc_e             acc_p;
        logic [LANES-1:0] mask_p;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_p  <= ACC_IDLE;
                mask_p <= '0;
            end else begin
                acc_p  <= acc_q;
                mask_p <= mask_q;
            end
        end
        assign out_acc  = acc_p;
        assign out_mask = mask_p;
    end else begin : g_flow
        assign out_acc  = acc_q;
        assign out_mask = mask_q;
    end

    // output process: only a read drives lanes (R4, R11)
    always_comb begin
        unique case (out_acc)
            ACC_READ:  read_lanes = out_mask;
            ACC_IDLE:  read_lanes = '0;
            ACC_WRITE: read_lanes = '0;
            ACC_SLEEP: read_lanes = '0;
            default:   read_lanes = '0;
        endcase
    end
endmodule

// File: rtl/lsp_mem.sv
module lsp_mem #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_stb,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_stb[g])
                cells[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        end
        assign rd_word[g*LANE_W +: LANE_W] = cells[rd_addr];
    end
endmodule

// File: rtl/lane_sram_port.sv
module lane_sram_port
    import lsp_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int LANE_W    = 9,
    parameter int ADDR_W    = 4,
    parameter bit PIPELINED = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n,
    input  logic                    sel,
    input  logic                    rd_nwr,
    input  logic [LANES-1:0]        lane_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    out_disable,
    input  logic                    doze,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        lane_drive
);
    localparam int WORD_W = LANES * LANE_W;

    acc_e              next_acc;
    logic [LANES-1:0]  lane_sel;
    logic [LANES-1:0]  wr_stb;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  read_lanes;
    logic [WORD_W-1:0] mem_word;
    logic [WORD_W-1:0] out_word;

    lsp_decode #(.LANES(LANES)) u_dec (
        .sel_n(sel_n), .sel(sel), .rd_nwr(rd_nwr), .doze(doze),
        .lane_en_n(lane_en_n), .next_acc(next_acc),
        .lane_sel(lane_sel), .wr_stb(wr_stb)
    );

    lsp_fsm #(.LANES(LANES), .ADDR_W(ADDR_W), .PIPELINED(PIPELINED)) u_fsm (
        .clk(clk), .rst_n(rst_n), .next_acc(next_acc), .lane_sel(lane_sel),
        .addr(addr), .addr_q(addr_q), .read_lanes(read_lanes)
    );

    lsp_mem #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .wr_stb(wr_stb), .wr_addr(addr), .wdata(wdata),
        .rd_addr(addr_q), .rd_word(mem_word)
    );

    // read data stage by timing variant (R8)
    if (PIPELINED) begin : g_pdata
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= mem_word;
        end
        assign out_word = word_q;
    end else begin : g_fdata
        assign out_word = mem_word;
    end

    // asynchronous quieting (R6, R7) and zeroing of idle lanes (R9)
    assign lane_drive = read_lanes & {LANES{~(out_disable | doze)}};

    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign rdata[g*LANE_W +: LANE_W] =
            lane_drive[g] ? out_word[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/lsp_check.sv
module lsp_check #(
    parameter int LANES     = 4,
    parameter bit PIPELINED = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_n,
    input logic             sel,
    input logic             rd_nwr,
    input logic [LANES-1:0] lane_en_n,
    input logic             out_disable,
    input logic             doze,
    input logic [LANES-1:0] wr_stb,
    input logic [LANES-1:0] lane_drive
);
    logic [1:0] cyc;
    logic       rd_acc;
    assign rd_acc = !sel_n && sel && rd_nwr && !doze;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    a_r6_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        out_disable |-> (lane_drive == '0));

    a_r7_doze_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        doze |-> (lane_drive == '0));

    a_r7_doze_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        doze |-> (wr_stb == '0));

    a_r2_desel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || !sel) |-> (wr_stb == '0));

    a_r3_strobe_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb & lane_en_n) == '0);

    if (PIPELINED) begin : g_pipe
        a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc >= 2'd2 && !out_disable && !doze) |->
            (lane_drive == ($past(rd_acc, 2) ? ~$past(lane_en_n, 2) : '0)));
    end else begin : g_flow
        a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc >= 2'd1 && !out_disable && !doze) |->
            (lane_drive == ($past(rd_acc) ? ~$past(lane_en_n) : '0)));
    end
endmodule

bind lane_sram_port lsp_check #(.LANES(LANES), .PIPELINED(PIPELINED)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .rd_nwr(rd_nwr),
    .lane_en_n(lane_en_n), .out_disable(out_disable), .doze(doze),
    .wr_stb(wr_stb), .lane_drive(lane_drive)
);

// File: tb/tb_lane_sram_port.sv
`timescale 1ns/100ps
module tb_lane_sram_port;
    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int ADDR_W = 4;
    localparam int WORD_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, sel = 1'b0, rd_nwr = 1'b1;
    logic [LANES-1:0]  lane_en_n = '1;
    logic [ADDR_W-1:0] addr = '0;
    logic [WORD_W-1:0] wdata = '0;
    logic out_disable = 1'b0, doze = 1'b0;
    logic [WORD_W-1:0] rdata_f, rdata_p;
    logic [LANES-1:0]  drive_f, drive_p;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_sram_port #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .PIPELINED(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .rd_nwr(rd_nwr),
        .lane_en_n(lane_en_n), .addr(addr), .wdata(wdata),
        .out_disable(out_disable), .doze(doze), .rdata(rdata_f), .lane_drive(drive_f));

    lane_sram_port #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .PIPELINED(1'b1)) dut_pipe (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .rd_nwr(rd_nwr),
        .lane_en_n(lane_en_n), .addr(addr), .wdata(wdata),
        .out_disable(out_disable), .doze(doze), .rdata(rdata_p), .lane_drive(drive_p));

    typedef struct {
        logic [LANES-1:0]  mask;
        logic [WORD_W-1:0] data;
        string             req;
    } exp_t;

    exp_t q_f[$];
    exp_t q_p[$];
    logic [WORD_W-1:0] model [DEPTH];
    int n_cmp = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    function automatic exp_t idle_item(string r);
        exp_t e;
        e.mask = '0; e.data = '0; e.req = r;
        return e;
    endfunction

    function automatic logic [WORD_W-1:0] pat(int a, int salt);
        return {9'(a*7 + salt), 9'(a*13 + 1 + salt), 9'(a*29 + 2), 9'(a*3 + salt*5 + 3)};
    endfunction

    task automatic check(string name, logic [LANES-1:0] am, logic [WORD_W-1:0] ad,
                         logic [LANES-1:0] em, logic [WORD_W-1:0] ed, string r);
        n_cmp++;
        if (am !== em || ad !== ed) begin
            n_bad++;
            $display("FAIL %s %s: drive=%b data=%h expected drive=%b data=%h",
                     r, name, am, ad, em, ed);
        end
    endtask

    // drive one access now and push its expected result for both instances
    task automatic drive_item(logic s_n, logic s, logic rw, logic [LANES-1:0] ben,
                              logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d,
                              logic dz, logic od, string r);
        exp_t e;
        bit selected;
        sel_n = s_n; sel = s; rd_nwr = rw; lane_en_n = ben; addr = a;
        wdata = d; doze = dz; out_disable = od;
        e = idle_item(r);
        selected = !s_n && s && !dz;
        for (int k = 0; k < LANES; k++) begin
            if (selected && !ben[k]) begin
                if (!rw)
                    model[a][k*LANE_W +: LANE_W] = d[k*LANE_W +: LANE_W];
                else begin
                    e.mask[k] = 1'b1;
                    e.data[k*LANE_W +: LANE_W] = model[a][k*LANE_W +: LANE_W];
                end
            end
        end
        q_f.push_back(e);
        q_p.push_back(e);
    endtask

    task automatic access(logic s_n, logic s, logic rw, logic [LANES-1:0] ben,
                          logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d,
                          logic dz, logic od, string r);
        @(posedge clk); #2;
        drive_item(s_n, s, rw, ben, a, d, dz, od, r);
    endtask

    task automatic wr(logic [LANES-1:0] ben, int a, logic [WORD_W-1:0] d, string r);
        access(1'b0, 1'b1, 1'b0, ben, ADDR_W'(a), d, 1'b0, 1'b0, r);
    endtask

    task automatic rd(logic [LANES-1:0] ben, int a, string r);
        access(1'b0, 1'b1, 1'b1, ben, ADDR_W'(a), '0, 1'b0, 1'b0, r);
    endtask

    task automatic idle(string r);
        access(1'b1, 1'b0, 1'b1, '1, '0, '0, 1'b0, 1'b0, r);
    endtask

    // scoreboard monitor: one item per instance per cycle
    always @(negedge clk) begin
        if (mon_on && !done) begin
            exp_t e;
            bit gate;
            gate = out_disable | doze;
            if (q_f.size() > 0) begin
                e = q_f.pop_front();
                if (gate) begin
                    e.mask = '0; e.data = '0;
                    e.req = out_disable ? "R6" : "R7";
                end
                check("flow", drive_f, rdata_f, e.mask, e.data, e.req);
            end
            if (q_p.size() > 0) begin
                e = q_p.pop_front();
                if (gate) begin
                    e.mask = '0; e.data = '0;
                    e.req = out_disable ? "R6" : "R7";
                end
                check("pipe", drive_p, rdata_p, e.mask, e.data, e.req);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R10: reset state
        repeat (2) begin
            @(negedge clk);
            check("flow reset", drive_f, rdata_f, '0, '0, "R10");
            check("pipe reset", drive_p, rdata_p, '0, '0, "R10");
        end
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        q_f.push_back(idle_item("R10"));
        q_p.push_back(idle_item("R10"));
        q_p.push_back(idle_item("R8"));
        mon_on = 1'b1;

        // R3/R1: fill every word through all lanes
        for (int a = 0; a < DEPTH; a++) wr(4'b0000, a, pat(a, 1), "R3");
        // R4/R8: read back all lanes
        for (int a = 0; a < DEPTH; a++) rd(4'b0000, a, "R4");

        // R3: partial writes, several lane mixes
        wr(4'b1010, 3, pat(40, 9), "R3");
        wr(4'b0111, 4, pat(41, 2), "R3");
        wr(4'b1001, 6, pat(42, 5), "R3");
        rd(4'b0000, 3, "R3");
        rd(4'b0000, 4, "R3");
        rd(4'b0000, 6, "R3");

        // R1/R9: one lane at a time and pairs
        for (int k = 0; k < LANES; k++) rd(~(4'b0001 << k), 5, "R1");
        rd(4'b1100, 7, "R9");
        rd(4'b0011, 7, "R9");

        // R5: all lane enables high
        rd(4'b1111, 2, "R5");
        wr(4'b1111, 2, pat(50, 7), "R5");
        rd(4'b0000, 2, "R5");

        // R2: every deselecting combination, for write and read
        access(1'b1, 1'b1, 1'b0, 4'b0000, 4'd8, pat(60, 3), 1'b0, 1'b0, "R2");
        access(1'b0, 1'b0, 1'b0, 4'b0000, 4'd8, pat(61, 3), 1'b0, 1'b0, "R2");
        access(1'b1, 1'b0, 1'b0, 4'b0000, 4'd8, pat(62, 3), 1'b0, 1'b0, "R2");
        access(1'b1, 1'b1, 1'b1, 4'b0000, 4'd8, '0, 1'b0, 1'b0, "R2");
        access(1'b0, 1'b0, 1'b1, 4'b0000, 4'd8, '0, 1'b0, 1'b0, "R2");
        rd(4'b0000, 8, "R2");

        // R11: read, write, read on one word back to back
        rd(4'b0000, 9, "R11");
        wr(4'b0000, 9, pat(70, 4), "R11");
        rd(4'b0000, 9, "R11");
        wr(4'b0110, 9, pat(71, 6), "R11");
        wr(4'b1001, 10, pat(72, 8), "R11");
        rd(4'b0000, 9, "R11");

        // R7: doze blocks a write and a read
        access(1'b0, 1'b1, 1'b0, 4'b0000, 4'd11, pat(80, 2), 1'b1, 1'b0, "R7");
        rd(4'b0000, 11, "R7");
        access(1'b0, 1'b1, 1'b1, 4'b0000, 4'd11, '0, 1'b1, 1'b0, "R7");
        idle("R7");

        // R6: disable high at flow sampling only; pipe copy still delivers
        rd(4'b0000, 12, "R6");
        access(1'b1, 1'b0, 1'b1, '1, '0, '0, 1'b0, 1'b1, "R6");
        idle("R6");

        // R6/R7: asynchronous quieting inside one cycle, no clock edge
        rd(4'b0101, 13, "R6");
        @(posedge clk); #1;
        out_disable = 1'b1; #0.5;
        check("flow async disable", drive_f, 36'h0, '0, '0, "R6");
        out_disable = 1'b0; #0.5;
        check("flow async restore", drive_f, 36'h0, 4'b1010, 36'h0, "R6");
        doze = 1'b1; #0.5;
        check("flow async doze", drive_f, rdata_f, '0, '0, "R7");
        doze = 1'b0; #0.5;
        drive_item(1'b1, 1'b0, 1'b1, '1, '0, '0, 1'b0, 1'b0, "R6");

        // mixed traffic from a small LFSR
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 60; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                access(lf[0] & lf[7], ~(lf[1] & lf[8]), lf[2], lf[6:3],
                       lf[12:9], pat(i, int'(lf[15:13])), 1'b0, 1'b0,
                       lf[2] ? "R4" : "R3");
            end
        end

        repeat (4) idle("R8");
        @(negedge clk); #1;
        finish_run();
    end
endmodule